// File: doc/BRIEF.md
# Dual PWM Gain-Control Loop

This block closes an automatic gain loop for a two-stage receiver front end. It reads a stream of magnitude samples from the converter and sums them over fixed windows of 2^WIN_LOG2 samples. At the end of each window it compares the sum against a programmed target level. The difference, scaled by a programmable right shift, goes into a saturating attenuation integrator. The upper eight bits of that integrator form a gain code. A larger code means more attenuation is needed.

A splitter turns the gain code into two duty values, one per amplifier stage, around a programmable take-over point. For small codes the tuner stays at full gain and only the IF stage backs off. Once the code reaches the take-over point, the IF stage is frozen and the tuner absorbs the rest. As an alternative, the IF duty can be taken straight from a register. Each stage has its own 8-bit PWM generator. These generators are paced by a prescaler enable that runs at no more than one step per 16 clocks. A new duty value is adopted only when the PWM period wraps, so no short pulses appear. External RC filters turn the pulse trains into analog control voltages.

Top module: `dual_agc_pwm`

## Requirements
- R1: While `rst` is high both PWM outputs are low. The first full PWM period after reset is driven with duty 128 on both outputs.
- R2: Each PWM counter is 8 bits wide and advances once every PRE_DIV clocks, where PRE_DIV is at least 16. An output is high while its counter is below its duty value, so duty D gives D×PRE_DIV high clocks in each 256×PRE_DIV-clock period. Duty 0 is never high.
- R3: The duty value in use changes only on the clock edge where the PWM counter wraps from 255 to 0.
- R4: The integrator changes only at the completion of a window of 2^WIN_LOG2 accepted samples (`smp_vld` high). A partial window has no effect.
- R5: Each window adds (sum of magnitudes − `cfg_target`×2^WIN_LOG2), arithmetically shifted right by `cfg_shift`, to the attenuation integrator.
- R6: The integrator saturates at 0 and at 2^INT_W−1 and never wraps.
- R7: The gain code is the integrator's top 8 bits, bits [INT_W−1:INT_W−8].
- R8: When the code is below `cfg_takeover`, the tuner duty is 255 and the IF duty is 255 − code.
- R9: When the code is at or above `cfg_takeover`, the IF duty is 255 − `cfg_takeover` and the tuner duty is 255 − (code − `cfg_takeover`).
- R10: When `cfg_if_fixed` is 1, the IF duty is `cfg_if_duty`. The tuner duty still follows R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Magnitude sample strobe |
| smp_mag | input | MAG_W | Unsigned sample magnitude |
| cfg_target | input | MAG_W | Target mean magnitude per sample |
| cfg_takeover | input | 8 | Gain code at which the tuner starts to back off |
| cfg_shift | input | SHIFT_W | Right shift applied to each window error |
| cfg_if_fixed | input | 1 | 1: IF duty taken from `cfg_if_duty` |
| cfg_if_duty | input | 8 | Fixed IF duty value |
| pwm_tun | output | 1 | Tuner gain PWM |
| pwm_if | output | 1 | IF gain PWM |

## Verification
The bench builds the block with WIN_LOG2 = 3. An eight-sample window lets several integration steps, both saturation limits and a partial window fit into a few dozen clocks of stimulus. MAG_W = 10, INT_W = 16 and PRE_DIV = 16 keep their default values. A full-scale error therefore moves the gain code by about 32 per window, and every duty can be read at the pins as high clocks divided by 16 over one 4096-clock period. Because reset places the counter at a known phase, the first period after reset can be measured exactly. This exposes both the mid-scale start and the rule that duty values only change at the wrap.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;

    localparam int DUTY_W = 8;
    localparam int NUM_CH = 2;
    localparam int CH_TUN = 0;
    localparam int CH_IF  = 1;

    typedef logic [DUTY_W-1:0] duty_t;

    localparam duty_t DUTY_MAX = '1;
    localparam duty_t DUTY_MID = duty_t'(1 << (DUTY_W - 1));

    typedef struct packed {
        duty_t tun;
        duty_t ifd;
    } duty_pair_t;

    typedef enum logic {
        IF_LOOP  = 1'b0,
        IF_FIXED = 1'b1
    } if_mode_e;

    // Two-stage gain split around the take-over code.
    function automatic duty_pair_t split_gain(input duty_t code, input duty_t tko);
        duty_pair_t p;
        if (code < tko) begin
            p.tun = DUTY_MAX;
            p.ifd = DUTY_MAX - code;
        end else begin
            p.ifd = DUTY_MAX - tko;
            p.tun = DUTY_MAX - (code - tko);
        end
        return p;
    endfunction

endpackage

// File: rtl/agc_window_acc.sv
`timescale 1ns/1ps
module agc_window_acc #(
    parameter int MAG_W    = 10,
    parameter int WIN_LOG2 = 9,
    localparam int ACC_W   = MAG_W + WIN_LOG2,
    localparam int ERR_W   = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic [MAG_W-1:0]        smp_mag,
    input  logic [MAG_W-1:0]        cfg_target,
    output logic                    err_vld,
    output logic signed [ERR_W-1:0] err
);

    logic [WIN_LOG2-1:0]     cnt_q;
    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        acc_nxt;
    logic [ACC_W-1:0]        tgt_tot;
    logic                    last;
    logic signed [ERR_W-1:0] diff;

    always_comb begin
        acc_nxt = acc_q + {{WIN_LOG2{1'b0}}, smp_mag};
        tgt_tot = {cfg_target, {WIN_LOG2{1'b0}}};
        last    = (cnt_q == '1);
        diff    = $signed({1'b0, acc_nxt}) - $signed({1'b0, tgt_tot});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            err_vld <= 1'b0;
            err     <= '0;
        end else begin
            err_vld <= 1'b0;
            if (smp_vld) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    acc_q   <= '0;
                    err_vld <= 1'b1;
                    err     <= diff;
                end else begin
                    acc_q <= acc_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/agc_integrator.sv
`timescale 1ns/1ps
module agc_integrator #(
    parameter int ERR_W   = 20,
    parameter int INT_W   = 16,
    parameter int SHIFT_W = 4,
    localparam int SUM_W  = ((ERR_W > INT_W) ? ERR_W : INT_W) + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err,
    input  logic [SHIFT_W-1:0]      shift,
    output logic [INT_W-1:0]        integ
);

    logic signed [SUM_W-1:0] err_ext;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] integ_ext;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] max_ext;
    logic [INT_W-1:0]        sat;

    always_comb begin
        err_ext   = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
        step      = err_ext >>> shift;
        integ_ext = $signed({{(SUM_W-INT_W){1'b0}}, integ});
        max_ext   = $signed({{(SUM_W-INT_W){1'b0}}, {INT_W{1'b1}}});
        sum       = integ_ext + step;
        if (sum[SUM_W-1])
            sat = '0;
        else if (sum > max_ext)
            sat = '1;
        else
            sat = sum[INT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            integ <= '0;
        else if (upd)
            integ <= sat;
    end

endmodule

// File: rtl/agc_split.sv
`timescale 1ns/1ps
module agc_split
    import agc_pkg::*;
(
    input  duty_t      code,
    input  duty_t      takeover,
    input  if_mode_e   mode,
    input  duty_t      fixed_duty,
    output duty_pair_t duty_out
);

    duty_pair_t loop_pair;

    always_comb begin
        loop_pair    = split_gain(code, takeover);
        duty_out.tun = loop_pair.tun;
        duty_out.ifd = (mode == IF_FIXED) ? fixed_duty : loop_pair.ifd;
    end

endmodule

// File: rtl/agc_pwm_ch.sv
`timescale 1ns/1ps
module agc_pwm_ch
    import agc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  duty_t duty_tgt,
    output logic  pwm,
    output duty_t cnt_o,
    output duty_t duty_o
);

    duty_t cnt_q;
    duty_t duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= DUTY_MID;
            pwm    <= 1'b0;
        end else begin
            pwm <= (cnt_q < duty_q);
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == DUTY_MAX)
                    duty_q <= duty_tgt;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign duty_o = duty_q;

endmodule

// File: rtl/dual_agc_pwm.sv
`timescale 1ns/1ps
module dual_agc_pwm
    import agc_pkg::*;
#(
    parameter int MAG_W    = 10,
    parameter int WIN_LOG2 = 9,
    parameter int INT_W    = 16,
    parameter int SHIFT_W  = 4,
    parameter int PRE_DIV  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_vld,
    input  logic [MAG_W-1:0]   smp_mag,
    input  logic [MAG_W-1:0]   cfg_target,
    input  logic [7:0]         cfg_takeover,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic               cfg_if_fixed,
    input  logic [7:0]         cfg_if_duty,
    output logic               pwm_tun,
    output logic               pwm_if
);

    localparam int ERR_W = MAG_W + WIN_LOG2 + 1;
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic                    win_done;
    logic signed [ERR_W-1:0] win_err;
    logic [INT_W-1:0]        integ;
    duty_t                   gain_code;
    duty_pair_t              tgt_pair;
    logic [PRE_W-1:0]        pre_q;
    logic                    tick;

    duty_t tgt_v  [NUM_CH];
    duty_t cnt_v  [NUM_CH];
    duty_t duty_v [NUM_CH];
    logic  pwm_v  [NUM_CH];

    agc_window_acc #(
        .MAG_W    (MAG_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .smp_mag    (smp_mag),
        .cfg_target (cfg_target),
        .err_vld    (win_done),
        .err        (win_err)
    );

    agc_integrator #(
        .ERR_W   (ERR_W),
        .INT_W   (INT_W),
        .SHIFT_W (SHIFT_W)
    ) u_int (
        .clk   (clk),
        .rst   (rst),
        .upd   (win_done),
        .err   (win_err),
        .shift (cfg_shift),
        .integ (integ)
    );

    assign gain_code = integ[INT_W-1 -: DUTY_W];

    agc_split u_split (
        .code       (gain_code),
        .takeover   (cfg_takeover),
        .mode       (if_mode_e'(cfg_if_fixed)),
        .fixed_duty (cfg_if_duty),
        .duty_out   (tgt_pair)
    );

    // Shared PWM rate enable.
    assign tick = (pre_q == PRE_W'(PRE_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tgt_v[CH_TUN] = tgt_pair.tun;
    assign tgt_v[CH_IF]  = tgt_pair.ifd;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        agc_pwm_ch u_pwm (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .duty_tgt (tgt_v[ch]),
            .pwm      (pwm_v[ch]),
            .cnt_o    (cnt_v[ch]),
            .duty_o   (duty_v[ch])
        );
    end

    assign pwm_tun = pwm_v[CH_TUN];
    assign pwm_if  = pwm_v[CH_IF];

endmodule

// File: rtl/agc_pwm_checker.sv
`timescale 1ns/1ps
module agc_pwm_checker
    import agc_pkg::*;
#(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             win_done,
    input logic [INT_W-1:0] integ,
    input duty_t            cnt_tun,
    input duty_t            cnt_if,
    input duty_t            duty_tun,
    input duty_t            duty_if,
    input duty_t            tgt_tun,
    input duty_t            tgt_if,
    input logic             cfg_if_fixed,
    input duty_t            cfg_takeover
);

    localparam int MIN_GAP = 15;

    logic [7:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick)
            gap_q <= '0;
        else if (gap_q != '1)
            gap_q <= gap_q + 1'b1;
    end

    // R1: duty registers start at mid-scale
    a_r1_mid_start: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (duty_tun == DUTY_MID && duty_if == DUTY_MID));

    // R2: counter steps no faster than one per 16 clocks
    a_r2_rate_limit: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q >= 8'(MIN_GAP)));

    // R2: both channel counters run in lockstep
    a_r2_lockstep: assert property (@(posedge clk) disable iff (rst)
        cnt_tun == cnt_if);

    // R3: duty changes only at the period wrap
    a_r3_wrap_only: assert property (@(posedge clk) disable iff (rst)
        (!$stable(duty_tun) || !$stable(duty_if)) |-> (cnt_tun == '0));

    // R4: integrator moves only after a completed window
    a_r4_window_update: assert property (@(posedge clk) disable iff (rst)
        !$stable(integ) |-> $past(win_done));

    // R9: tuner backs off only with IF held at the take-over level
    a_r9_if_frozen: assert property (@(posedge clk) disable iff (rst)
        (!cfg_if_fixed && tgt_tun != DUTY_MAX) |-> (tgt_if == ~cfg_takeover));

endmodule

bind dual_agc_pwm agc_pwm_checker #(.INT_W(INT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .win_done     (win_done),
    .integ        (integ),
    .cnt_tun      (cnt_v[agc_pkg::CH_TUN]),
    .cnt_if       (cnt_v[agc_pkg::CH_IF]),
    .duty_tun     (duty_v[agc_pkg::CH_TUN]),
    .duty_if      (duty_v[agc_pkg::CH_IF]),
    .tgt_tun      (tgt_pair.tun),
    .tgt_if       (tgt_pair.ifd),
    .cfg_if_fixed (cfg_if_fixed),
    .cfg_takeover (cfg_takeover)
);

// File: tb/dual_agc_pwm_tb.sv
`timescale 1ns/1ps
module dual_agc_pwm_tb;

    localparam int MAG_W    = 10;
    localparam int WIN_LOG2 = 3;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int PRE_DIV  = 16;
    localparam int PERIOD   = 256 * PRE_DIV;
    localparam int WDOG     = 160000;

    typedef struct packed {
        logic [9:0] mag;
        logic [9:0] tgt;
        logic [3:0] shf;
        logic [7:0] nwin;
        logic [7:0] tko;
        logic       fix;
        logic [7:0] fdu;
        logic [7:0] etun;
        logic [7:0] eif;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10'd100,  10'd100,  4'd0, 8'd4,  8'd64,  1'b0, 8'd0,  8'd255, 8'd255}, // R5 zero error
        '{10'd612,  10'd100,  4'd0, 8'd4,  8'd100, 1'b0, 8'd0,  8'd255, 8'd191}, // R7 R8 code 64
        '{10'd612,  10'd100,  4'd0, 8'd4,  8'd40,  1'b0, 8'd0,  8'd231, 8'd215}, // R9 code 64 over 40
        '{10'd612,  10'd100,  4'd2, 8'd4,  8'd100, 1'b0, 8'd0,  8'd255, 8'd239}, // R5 shift 2, code 16
        '{10'd1023, 10'd0,    4'd0, 8'd10, 8'd40,  1'b0, 8'd0,  8'd40,  8'd215}, // R6 top saturation
        '{10'd0,    10'd1023, 4'd0, 8'd2,  8'd64,  1'b0, 8'd0,  8'd255, 8'd255}, // R6 floor
        '{10'd612,  10'd100,  4'd0, 8'd4,  8'd40,  1'b1, 8'd77, 8'd231, 8'd77},  // R10 fixed IF
        '{10'd100,  10'd100,  4'd0, 8'd1,  8'd64,  1'b1, 8'd0,  8'd255, 8'd0},   // R2 duty zero
        '{10'd612,  10'd100,  4'd0, 8'd4,  8'd64,  1'b0, 8'd0,  8'd255, 8'd191}  // R9 code equal to take-over
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic [MAG_W-1:0] smp_mag = '0;
    logic [MAG_W-1:0] cfg_target = '0;
    logic [7:0]       cfg_takeover = '0;
    logic [3:0]       cfg_shift = '0;
    logic             cfg_if_fixed = 1'b0;
    logic [7:0]       cfg_if_duty = '0;
    logic             pwm_tun;
    logic             pwm_if;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_agc_pwm #(
        .MAG_W    (MAG_W),
        .WIN_LOG2 (WIN_LOG2),
        .INT_W    (16),
        .SHIFT_W  (4),
        .PRE_DIV  (PRE_DIV)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .smp_vld      (smp_vld),
        .smp_mag      (smp_mag),
        .cfg_target   (cfg_target),
        .cfg_takeover (cfg_takeover),
        .cfg_shift    (cfg_shift),
        .cfg_if_fixed (cfg_if_fixed),
        .cfg_if_duty  (cfg_if_duty),
        .pwm_tun      (pwm_tun),
        .pwm_if       (pwm_if)
    );

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 outputs low in reset", int'({pwm_tun, pwm_if}), 0);
        rst = 1'b0;
    endtask

    task automatic feed(input int mag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            smp_mag = MAG_W'(mag);
        end
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic measure(output int hi_tun, output int hi_if);
        hi_tun = 0;
        hi_if  = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            hi_tun += int'(pwm_tun);
            hi_if  += int'(pwm_if);
        end
    endtask

    initial begin
        int ht, hi;
        string tag;

        // R1 R3: first period keeps mid-scale even though a new IF duty is programmed
        cfg_if_fixed = 1'b1;
        cfg_if_duty  = 8'd200;
        cfg_takeover = 8'd64;
        do_reset();
        measure(ht, hi);
        check("R1 R3 first period tuner high clocks", ht, 128 * PRE_DIV);
        check("R1 R3 first period IF high clocks", hi, 128 * PRE_DIV);
        measure(ht, hi);
        check("R3 R10 second period IF high clocks", hi, 200 * PRE_DIV);
        check("R2 R8 second period tuner high clocks", ht, 255 * PRE_DIV);

        // Vector table: one reset per row, then integrate and read the duties at the pins
        for (int v = 0; v < NV; v++) begin
            cfg_target   = VECS[v].tgt;
            cfg_shift    = VECS[v].shf;
            cfg_takeover = VECS[v].tko;
            cfg_if_fixed = VECS[v].fix;
            cfg_if_duty  = VECS[v].fdu;
            do_reset();
            feed(int'(VECS[v].mag), int'(VECS[v].nwin) * WIN);
            repeat (PERIOD + 32) @(negedge clk);
            measure(ht, hi);
            tag = $sformatf("R5 R8 R9 R10 vector %0d tuner", v);
            check(tag, ht, int'(VECS[v].etun) * PRE_DIV);
            tag = $sformatf("R5 R8 R9 R10 vector %0d IF", v);
            check(tag, hi, int'(VECS[v].eif) * PRE_DIV);
        end

        // R4: a partial window leaves the loop untouched, the closing sample applies it
        cfg_target   = '0;
        cfg_shift    = '0;
        cfg_takeover = 8'd64;
        cfg_if_fixed = 1'b0;
        do_reset();
        feed(1023, WIN - 1);
        repeat (PERIOD + 32) @(negedge clk);
        measure(ht, hi);
        check("R4 partial window IF", hi, 255 * PRE_DIV);
        feed(1023, 1);
        repeat (PERIOD + 32) @(negedge clk);
        measure(ht, hi);
        check("R4 R7 completed window IF (code 31)", hi, 224 * PRE_DIV);
        check("R4 R8 completed window tuner", ht, 255 * PRE_DIV);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule